// File: doc/BRIEF.md
# Free-Running Watchdog with Edge-Gated Reset

The block is a watchdog down-counter that can never be halted. Software programs an 8-bit timeout, picks a time base of seconds or minutes, and decides whether an expiry may reset the system. Writing the timeout register loads the counter and restarts the countdown. This write is the only way to service the timer. While the output enable is clear the counter still runs, and an expiry only raises a flag.

On expiry a sticky event flag is set, which software clears by writing 1. A reset pulse of fixed length goes out only when that flag goes from 0 to 1 while the output enable is set. Turning the enable on after the flag is already set does not start a reset, and neither does a second expiry while the flag is still set. A one-second strobe drives the block. A divide-by-60 prescaler inside the block derives the minute units from it.

Top module: `wdg_gated_watchdog`

## Requirements
- R1: After reset, address 0 (timeout) reads 60, address 1 (time base) reads 0x01, address 2 (output enable) reads 0x00, address 3 (event) reads 0x00, and `wdg_event` and `wdg_rst` are low.
- R2: Address 0 stores all 8 bits. Address 1 keeps only bit 0 (1 = seconds, 0 = minutes). Address 2 keeps only bit 1 (reset enable). Unkept bits read 0. Addresses 4 and above read 0, and writes to them change nothing.
- R3: With the second time base, after timeout N (N ≥ 1) is written, the event flag sets at the edge that samples the N-th `sec_tick` and not before.
- R4: With the minute time base, the count moves once every 60 `sec_tick` strobes, so timeout N sets the event on the (60·N)-th strobe.
- R5: A timeout write reloads the counter and clears the minute prescaler, so the countdown restarts in full. A write in the same cycle as a tick takes priority over the tick.
- R6: A timeout value of 0 sets the event on the next unit tick.
- R7: After an expiry the counter holds at zero and does not expire again until the timeout is rewritten.
- R8: The event flag reads at address 3 bit 0 and drives `wdg_event`. It is sticky. Writing 1 to bit 0 clears it, and writing 0 has no effect.
- R9: An expiry that takes the flag from 0 to 1 while output-enable bit 1 is set drives `wdg_rst` high for exactly RST_CYCLES clocks, starting on the clock after that edge.
- R10: Setting the output enable while the flag is already set does not drive `wdg_rst`.
- R11: An expiry while the flag is still set does not drive `wdg_rst`, even with the output enable set.
- R12: With the output enable clear, the counter still runs and expiry still sets the flag, but `wdg_rst` stays low.
- R13: When an expiry and a clear write to the flag happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| wdg_event | output | 1 | Sticky expiry flag |
| wdg_rst | output | 1 | System reset pulse |

## Verification
A wrong count or prescaler state shows up only when the event flag appears. It can show up up to 255 minutes later, so the bench uses small timeouts and checks `wdg_event` on the exact edge. A stale flag or wrong edge state shows up as a reset pulse that is missing, extra or the wrong length on `wdg_rst` in the cycle after expiry. A cycle-accurate reference model in the bench compares both outputs and the read data on every clock of a random run. A divergence is therefore reported on the first clock that it reaches a port.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // register selector (low two address bits)
   typedef enum logic [1:0] {
      RA_TIMEOUT = 2'd0,
      RA_TBASE   = 2'd1,
      RA_OUTEN   = 2'd2,
      RA_EVENT   = 2'd3
   } wdg_reg_e;

   // bit positions software depends on
   localparam int unsigned TB_SEC_BIT = 0;
   localparam int unsigned OUTEN_BIT  = 1;
   localparam int unsigned EVENT_BIT  = 0;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned RST_TIMEOUT = 60,
   parameter bit          RST_TB_SEC  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              evt_flag,
   output logic [DATA_W-1:0] rdata,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic              tb_sec,
   output logic              out_en,
   output logic              evt_clr
);

   localparam int unsigned SEL_W = 2;

   if (ADDR_W < SEL_W) begin : g_bad_addr
      $error("wdg_regs: ADDR_W must be at least 2");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("wdg_regs: CNT_W must not exceed DATA_W");
   end
   if (DATA_W <= OUTEN_BIT) begin : g_bad_data
      $error("wdg_regs: DATA_W too narrow for field layout");
   end

   logic             hit;
   wdg_reg_e         sel;
   logic [CNT_W-1:0] timeout_q;
   logic             tb_q;
   logic             oe_q;

   assign hit = ((addr >> SEL_W) == '0);
   assign sel = wdg_reg_e'(addr[SEL_W-1:0]);

   assign load    = wr_en && hit && (sel == RA_TIMEOUT);
   assign evt_clr = wr_en && hit && (sel == RA_EVENT) && wdata[EVENT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timeout_q <= CNT_W'(RST_TIMEOUT);
         tb_q      <= RST_TB_SEC;
         oe_q      <= 1'b0;
      end else if (wr_en && hit) begin
         case (sel)
            RA_TIMEOUT: timeout_q <= wdata[CNT_W-1:0];
            RA_TBASE:   tb_q      <= wdata[TB_SEC_BIT];
            RA_OUTEN:   oe_q      <= wdata[OUTEN_BIT];
            default:    ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         case (sel)
            RA_TIMEOUT: rdata[CNT_W-1:0]  = timeout_q;
            RA_TBASE:   rdata[TB_SEC_BIT] = tb_q;
            RA_OUTEN:   rdata[OUTEN_BIT]  = oe_q;
            RA_EVENT:   rdata[EVENT_BIT]  = evt_flag;
            default:    rdata = '0;
         endcase
      end
   end

   assign load_val = wdata[CNT_W-1:0];
   assign tb_sec   = tb_q;
   assign out_en   = oe_q;

   // R2: configuration holds when no write is presented
   a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(timeout_q) && $stable(tb_q) && $stable(oe_q)));

endmodule

// File: rtl/wdg_tick.sv
module wdg_tick #(
   parameter int unsigned MIN_DIV = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic restart,
   input  logic tb_sec,
   output logic unit_tick
);

   if (MIN_DIV < 1) begin : g_bad_div
      $error("wdg_tick: MIN_DIV must be at least 1");
   end

   logic min_tick;

   if (MIN_DIV == 1) begin : g_nodiv
      logic unused_restart;
      assign unused_restart = restart;
      assign min_tick       = sec_tick;
   end else begin : g_div
      localparam int unsigned PRE_W = $clog2(MIN_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MIN_DIV - 1);

      logic [PRE_W-1:0] pre_q;
      logic             wrap;

      assign wrap     = (pre_q == PRE_LAST);
      assign min_tick = sec_tick && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pre_q <= '0;
         else if (restart)    pre_q <= '0;
         else if (sec_tick)   pre_q <= wrap ? '0 : pre_q + 1'b1;
      end

      // R5: prescaler restarts from zero on a reload
      a_r5_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
         restart |=> (pre_q == '0));
   end

   assign unit_tick = tb_sec ? sec_tick : min_tick;

   // R4: no unit tick without an underlying second strobe
   a_r4_tick_src: assert property (@(posedge clk) disable iff (!rst_n)
      unit_tick |-> sec_tick);

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned RST_TIMEOUT = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             unit_tick,
   output logic             expire
);

   if (RST_TIMEOUT >= (1 << CNT_W)) begin : g_bad_rst
      $error("wdg_count: RST_TIMEOUT does not fit CNT_W");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             step;

   assign step   = unit_tick && !load && !done_q;
   assign expire = step && (cnt_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_W'(RST_TIMEOUT);
         done_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= load_val;
         done_q <= 1'b0;
      end else if (step) begin
         cnt_q  <= (cnt_q == '0) ? '0 : cnt_q - ONE;
         done_q <= (cnt_q <= ONE);
      end
   end

   // R3: each unit tick above one takes exactly one count off
   a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_tick && !load && !done_q && cnt_q > ONE) |=>
         (cnt_q == CNT_W'($past(cnt_q) - ONE)));

   // R7: after expiry the counter parks at zero until reloaded
   a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !load) |=> (done_q && cnt_q == '0));

endmodule

// File: rtl/wdg_evt.sv
module wdg_evt #(
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic evt_clr,
   input  logic out_en,
   output logic evt_flag,
   output logic sys_rst
);

   if (RST_CYCLES < 1) begin : g_bad_len
      $error("wdg_evt: RST_CYCLES must be at least 1");
   end

   localparam int unsigned RC_W = $clog2(RST_CYCLES + 1);
   localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);

   logic            evt_q;
   logic [RC_W-1:0] rc_q;
   logic            fire;

   // reset is decided only on the 0->1 transition of the flag
   assign fire = expire && !evt_q && out_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        evt_q <= 1'b0;
      else if (expire)   evt_q <= 1'b1;
      else if (evt_clr)  evt_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rc_q <= '0;
      else if (fire)        rc_q <= RC_LOAD;
      else if (rc_q != '0)  rc_q <= rc_q - 1'b1;
   end

   assign evt_flag = evt_q;
   assign sys_rst  = (rc_q != '0);

   // R8: flag is sticky without a clear request
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q && !evt_clr) |=> evt_q);

   // R9: a reset pulse begins only on a flag rise with output enabled
   a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> ($rose(evt_q) && $past(out_en)));

   // R11: expiry with the flag already set never starts a pulse
   a_r11_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q && expire && !sys_rst) |=> !sys_rst);

   // R13: expiry wins over a same-cycle clear
   a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && evt_clr) |=> evt_q);

endmodule

// File: rtl/wdg_gated_watchdog.sv
module wdg_gated_watchdog #(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned MIN_DIV     = 60,
   parameter int unsigned RST_CYCLES  = 4,
   parameter int unsigned RST_TIMEOUT = 60,
   parameter bit          RST_TB_SEC  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              wdg_event,
   output logic              wdg_rst
);

   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             tb_sec;
   logic             out_en;
   logic             evt_clr;
   logic             unit_tick;
   logic             expire;
   logic             evt_flag;

   wdg_regs #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .RST_TIMEOUT(RST_TIMEOUT),
      .RST_TB_SEC (RST_TB_SEC)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .evt_flag(evt_flag),
      .rdata   (reg_rdata),
      .load    (load),
      .load_val(load_val),
      .tb_sec  (tb_sec),
      .out_en  (out_en),
      .evt_clr (evt_clr)
   );

   wdg_tick #(
      .MIN_DIV(MIN_DIV)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .restart  (load),
      .tb_sec   (tb_sec),
      .unit_tick(unit_tick)
   );

   wdg_count #(
      .CNT_W      (CNT_W),
      .RST_TIMEOUT(RST_TIMEOUT)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .unit_tick(unit_tick),
      .expire   (expire)
   );

   wdg_evt #(
      .RST_CYCLES(RST_CYCLES)
   ) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (expire),
      .evt_clr (evt_clr),
      .out_en  (out_en),
      .evt_flag(evt_flag),
      .sys_rst (wdg_rst)
   );

   assign wdg_event = evt_flag;

   // R12: with output disabled, no pulse can start
   a_r12_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en && !wdg_rst) |=> !wdg_rst);

endmodule

// File: tb/tb_wdg_gated_watchdog.sv
`timescale 1ns/1ps
module tb_wdg_gated_watchdog;

   localparam int ADDR_W  = 3;
   localparam int DATA_W  = 8;
   localparam int DIV     = 60;
   localparam int RCYC    = 4;
   localparam int RTO     = 60;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sec_tick = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              wdg_event;
   logic              wdg_rst;

   int checks = 0;
   int errors = 0;

   // reference state
   int m_to, m_tb, m_oe, m_cnt, m_done, m_pre, m_evt, m_rc;

   always #2.5 clk = ~clk;

   wdg_gated_watchdog #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_DIV(DIV),
      .RST_CYCLES(RCYC), .RST_TIMEOUT(RTO)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wdg_event(wdg_event), .wdg_rst(wdg_rst)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int mread(input int a);
      case (a)
         0: return m_to;
         1: return m_tb;
         2: return m_oe << 1;
         3: return m_evt;
         default: return 0;
      endcase
   endfunction

   task automatic mstep(input int tk, input int wr, input int a, input int d);
      int ld, mt, ut, ex, clr;
      ld  = wr && a == 0;
      mt  = tk && m_pre == DIV - 1;
      ut  = m_tb ? tk : mt;
      ex  = ut && !ld && !m_done && m_cnt <= 1;
      clr = wr && a == 3 && d[0];
      if (m_rc != 0) m_rc = m_rc - 1;
      if (ex && !m_evt && m_oe) m_rc = RCYC;
      if (ex) m_evt = 1; else if (clr) m_evt = 0;
      if (ld) m_pre = 0; else if (tk) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      if (ld) begin m_cnt = d & 255; m_done = 0; end
      else if (ut && !m_done) begin
         if (m_cnt <= 1) m_done = 1;
         m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
      end
      if (wr && a == 1) m_tb = d & 1;
      if (wr && a == 2) m_oe = (d >> 1) & 1;
      if (ld) m_to = d & 255;
   endtask

   // one clock: drive, check read data, clock, check outputs against model
   task automatic cyc(input int tk, input int wr, input int a, input int d);
      sec_tick  = tk[0];
      reg_wr    = wr[0];
      reg_addr  = a[ADDR_W-1:0];
      reg_wdata = d[DATA_W-1:0];
      #1;
      chk("R2 rdata", int'(reg_rdata), mread(a));
      @(posedge clk);
      mstep(tk, wr, a, d);
      #1;
      chk("R8 event", int'(wdg_event), m_evt);
      chk("R9 rst", int'(wdg_rst), m_rc != 0);
      sec_tick = 1'b0;
      reg_wr   = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      cyc(0, 1, a, d);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
   endtask

   task automatic rd(input int a, output int v);
      reg_addr = a[ADDR_W-1:0];
      #0.5;
      v = int'(reg_rdata);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v;
      int n;
      void'($urandom(32'd20240611));
      m_to = RTO; m_tb = 1; m_oe = 0; m_cnt = RTO; m_done = 0;
      m_pre = 0; m_evt = 0; m_rc = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(0, v); chk("R1 timeout", v, 60);
      rd(1, v); chk("R1 tbase", v, 1);
      rd(2, v); chk("R1 outen", v, 0);
      rd(3, v); chk("R1 event", v, 0);
      chk("R1 wdg_rst", int'(wdg_rst), 0);

      // R2 field masking and unmapped addresses
      wr(1, 8'hFF); rd(1, v); chk("R2 tbase mask", v, 1);
      wr(2, 8'hFF); rd(2, v); chk("R2 outen mask", v, 2);
      wr(2, 8'h00);
      wr(0, 8'hA5); rd(0, v); chk("R2 timeout", v, 8'hA5);
      wr(4, 8'h00); rd(0, v); chk("R2 unmapped write", v, 8'hA5);
      rd(4, v); chk("R2 unmapped read", v, 0);

      // R3 second base
      wr(1, 1); wr(0, 3); ticks(2);
      chk("R3 before N", int'(wdg_event), 0);
      ticks(1);
      chk("R3 at N", int'(wdg_event), 1);
      // R8 write 0 keeps, write 1 clears
      wr(3, 0); chk("R8 write0", int'(wdg_event), 1);
      wr(3, 1); chk("R8 clear", int'(wdg_event), 0);
      // R7 parked counter
      ticks(5); chk("R7 parked", int'(wdg_event), 0);
      // R6 zero timeout
      wr(0, 0); ticks(1); chk("R6 zero", int'(wdg_event), 1);
      wr(3, 1);
      // R5 restart
      wr(0, 2); ticks(1); wr(0, 2); ticks(1);
      chk("R5 restarted", int'(wdg_event), 0);
      ticks(1); chk("R5 expire", int'(wdg_event), 1);
      wr(3, 1);
      // R5 tick and reload same cycle: reload wins
      wr(0, 1); cyc(1, 1, 0, 1);
      chk("R5 load priority", int'(wdg_event), 0);
      ticks(1); chk("R5 after load", int'(wdg_event), 1);
      wr(3, 1);

      // R4 minute base
      wr(1, 0); wr(0, 2); ticks(119);
      chk("R4 before", int'(wdg_event), 0);
      ticks(1); chk("R4 at 120", int'(wdg_event), 1);
      wr(3, 1);
      // R5 prescaler cleared by reload
      wr(0, 1); ticks(30); wr(0, 1); ticks(59);
      chk("R5 prescaler", int'(wdg_event), 0);
      ticks(1); chk("R5 prescaler expire", int'(wdg_event), 1);
      wr(3, 1); wr(1, 1);

      // R9 gated pulse
      wr(2, 2); wr(0, 1); ticks(1);
      chk("R9 start", int'(wdg_rst), 1);
      n = 0;
      while (wdg_rst && n < 20) begin n++; cyc(0, 0, 3, 0); end
      chk("R9 length", n, RCYC);
      // R11 expiry with flag still set
      wr(0, 1); ticks(1);
      chk("R11 flag", int'(wdg_event), 1);
      chk("R11 no rst", int'(wdg_rst), 0);
      // R10 enable after expiry
      wr(3, 1); wr(2, 0); wr(0, 1); ticks(1);
      wr(2, 2); cyc(0, 0, 3, 0); cyc(0, 0, 3, 0);
      chk("R10 no rst", int'(wdg_rst), 0);
      wr(3, 1);
      // R12 disabled output, counter still runs
      wr(2, 0); wr(0, 2); ticks(2);
      chk("R12 flag", int'(wdg_event), 1);
      chk("R12 no rst", int'(wdg_rst), 0);
      wr(3, 1);
      // R13 set beats clear
      wr(0, 1); cyc(1, 1, 3, 1);
      chk("R13 set wins", int'(wdg_event), 1);
      wr(3, 1);

      // random phase against the model
      for (int i = 0; i < 4000; i++) begin
         int tk, w, a, d;
         tk = ($urandom % 3) == 0;
         w  = ($urandom % 12) == 0;
         a  = $urandom % 5;
         d  = $urandom % 256;
         if (a == 0) d = $urandom % 6;
         if (a == 1 && ($urandom % 4) != 0) d = d | 1;
         cyc(tk, w, a, d);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule